// File: doc/BRIEF.md
# Ping-Pong Receive Buffer for a Bulk OUT Endpoint

This block holds received packets for one bulk OUT endpoint. It sits between the USB serial engine and a processor register port. Packets land in two slots that are used in turn. The engine streams the bytes of a packet into the slot that is next in line and then closes the packet with an end strobe. Each closed packet counts as complete, and the processor drains it one byte per read of a 32-bit data register.

Before each OUT token the engine asks for a handshake decision. The block answers ACK only when the next slot in line is completely empty, meaning software has read every byte of it. Otherwise it answers NAK, and it keeps answering NAK until that whole slot is free.

An interrupt is raised once per good packet, at its end. It is not raised per byte. A packet that arrives flagged bad, or that runs past the slot size, is thrown away without any trace.

Top module: `usb_out_pingpong`

## Requirements
- R1: Two slots of DEPTH (64) bytes each are filled in turn, and the processor reads packets back in the order they arrived.
- R2: A pulse on `tok_req` produces, on the next cycle, a one-cycle `tok_resp_valid` with `tok_resp_nak` = 0 (ACK) when the next slot in line is empty and no reception is open. An ACK opens a reception into that slot.
- R3: `tok_resp_nak` = 1 when the next slot in line still holds a packet, including one that is partly read. The NAK holds for every later token until the last byte of that packet has been read.
- R4: `rx_eop` arrives in a cycle with no data byte. A good end of packet gives a one-cycle `pkt_ack` on the next cycle and sets `irq` one cycle after that. Data bytes alone never set `irq`.
- R5: A packet ends discarded if `rx_bad` is high together with `rx_eop`, or if more than DEPTH bytes arrived. A discarded packet gives no `pkt_ack` and no `irq`, leaves `ready_cnt` unchanged, and leaves its slot free, so the next token is ACKed.
- R6: A read strobe `rd_en` returns the head byte of the oldest packet in `rd_data[7:0]` on the next cycle, with `rd_data[31:8]` = 0.
- R7: `ready_cnt` gives the number of complete packets not yet fully read (0 to 2). `head_len` gives the byte count of the oldest one, or 0 when there is none.
- R8: `irq` stays high until a one-cycle write of `irq_clr`. If two complete packets are waiting at that moment, `irq` stays high.
- R9: A read while no packet is ready returns 0 and moves no pointer. The next packet received is still read from its first byte.
- R10: After reset, `rd_data`, `irq`, `ready_cnt` and `head_len` are all 0, and the first token is ACKed.
- R11: Bytes strobed while no ACKed reception is open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_req | input | 1 | Engine asks for the handshake of an OUT token |
| rx_valid | input | 1 | Received data byte strobe |
| rx_data | input | 8 | Received data byte |
| rx_eop | input | 1 | End of packet strobe, alone in its cycle |
| rx_bad | input | 1 | Packet failed checks; sampled with rx_eop |
| tok_resp_valid | output | 1 | Handshake decision valid |
| tok_resp_nak | output | 1 | 1 = NAK, 0 = ACK |
| pkt_ack | output | 1 | Good packet stored, send ACK |
| rd_en | input | 1 | Processor read of the data register |
| irq_clr | input | 1 | Processor write-one-to-clear of the interrupt |
| rd_data | output | 32 | Data register value, byte in 7:0 |
| irq | output | 1 | Packet-received interrupt |
| ready_cnt | output | 2 | Complete packets waiting |
| head_len | output | 7 | Byte count of oldest waiting packet |

## Verification
The bench fills both slots and then sends a token while the head packet is only half read. A design that frees a slot on its first read would ACK at that point and overwrite data that has not been read yet.

It sends a bad packet, a 65-byte packet and a full 64-byte packet. This catches a design that commits, interrupts or ACKs on a discard, and a design that is off by one at the size limit.

It also clears the interrupt while two packets wait, reads with nothing ready, and strobes stray bytes with no reception open. Getting these wrong shows up as a lost interrupt, a shifted read pointer, or corrupted lengths and data.

// File: rtl/usb_out_pkg.sv
package usb_out_pkg;
    localparam int unsigned SLOT_BYTES = 64;
    localparam int unsigned NUM_SLOTS  = 2;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned REG_W      = 32;
endpackage

// File: rtl/pkt_slot_ram.sv
module pkt_slot_ram #(
    parameter int unsigned DEPTH = usb_out_pkg::SLOT_BYTES,
    parameter int unsigned DW    = usb_out_pkg::DATA_W,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wslot,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rslot,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned WORDS = 2 * DEPTH;

    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[{wslot, waddr}] <= wdata;
        end
    end

    assign rdata = mem_q[{rslot, raddr}];
endmodule

// File: rtl/ep_rx_fill.sv
module ep_rx_fill #(
    parameter int unsigned DEPTH = usb_out_pkg::SLOT_BYTES,
    parameter int unsigned DW    = usb_out_pkg::DATA_W,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_req,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_eop,
    input  logic          rx_bad,
    input  logic [1:0]    slot_full,
    output logic          tok_resp_valid,
    output logic          tok_resp_nak,
    output logic          pkt_ack,
    output logic          wr_en,
    output logic          wr_slot,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          commit_valid,
    output logic          commit_slot,
    output logic [LW-1:0] commit_len
);
    typedef struct packed {
        logic          filling;
        logic          slot;
        logic [LW-1:0] cnt;
        logic          ovf;
        logic          resp_valid;
        logic          resp_nak;
        logic          ack;
        logic          cm_valid;
        logic          cm_slot;
        logic [LW-1:0] cm_len;
    } fill_st_t;

    fill_st_t st_d, st_q;
    logic at_limit;

    assign at_limit = (st_q.cnt == LW'(DEPTH));

    always_comb begin
        st_d            = st_q;
        st_d.resp_valid = 1'b0;
        st_d.ack        = 1'b0;
        st_d.cm_valid   = 1'b0;

        if (tok_req) begin
            st_d.resp_valid = 1'b1;
            if (st_q.filling || slot_full[st_q.slot]) begin
                st_d.resp_nak = 1'b1;
            end else begin
                st_d.resp_nak = 1'b0;
                st_d.filling  = 1'b1;
                st_d.cnt      = '0;
                st_d.ovf      = 1'b0;
            end
        end

        if (st_q.filling && rx_valid) begin
            if (at_limit) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + LW'(1);
            end
        end

        if (st_q.filling && rx_eop) begin
            st_d.filling = 1'b0;
            if (!rx_bad && !st_q.ovf) begin
                st_d.cm_valid = 1'b1;
                st_d.cm_slot  = st_q.slot;
                st_d.cm_len   = st_q.cnt;
                st_d.ack      = 1'b1;
                st_d.slot     = ~st_q.slot;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tok_resp_valid = st_q.resp_valid;
    assign tok_resp_nak   = st_q.resp_nak;
    assign pkt_ack        = st_q.ack;
    assign wr_en          = st_q.filling && rx_valid && !at_limit;
    assign wr_slot        = st_q.slot;
    assign wr_addr        = st_q.cnt[AW-1:0];
    assign wr_data        = rx_data;
    assign commit_valid   = st_q.cm_valid;
    assign commit_slot    = st_q.cm_slot;
    assign commit_len     = st_q.cm_len;

    // R3
    nak_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_req && slot_full[st_q.slot]) |=> (tok_resp_valid && tok_resp_nak));

    // R5
    no_ack_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_eop && rx_bad) |=> !pkt_ack);

    // R2
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_resp_valid |-> $past(tok_req));
endmodule

// File: rtl/ep_rd_drain.sv
module ep_rd_drain #(
    parameter int unsigned DEPTH = usb_out_pkg::SLOT_BYTES,
    parameter int unsigned DW    = usb_out_pkg::DATA_W,
    parameter int unsigned RW    = usb_out_pkg::REG_W,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit_valid,
    input  logic          commit_slot,
    input  logic [LW-1:0] commit_len,
    input  logic          rd_en,
    input  logic          irq_clr,
    input  logic [DW-1:0] ram_rdata,
    output logic          ram_rslot,
    output logic [AW-1:0] ram_raddr,
    output logic [1:0]    slot_full,
    output logic [RW-1:0] rd_data,
    output logic          irq,
    output logic [1:0]    ready_cnt,
    output logic [LW-1:0] head_len
);
    typedef struct packed {
        logic [1:0]          full;
        logic [1:0][LW-1:0]  len;
        logic                head;
        logic [LW-1:0]       ptr;
        logic [DW-1:0]       rdata;
        logic                irq;
    } drain_st_t;

    drain_st_t st_d, st_q;
    logic [LW-1:0] ptr_inc;
    logic [LW-1:0] len_of [2];

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_len
            assign len_of[g] = st_q.len[g];
        end
    endgenerate

    assign ptr_inc = st_q.ptr + LW'(1);

    always_comb begin
        st_d = st_q;

        if (irq_clr) begin
            st_d.irq = (st_q.full == 2'b11);
        end

        if (rd_en) begin
            if (st_q.full[st_q.head]) begin
                st_d.rdata = (len_of[st_q.head] == '0) ? '0 : ram_rdata;
                if (ptr_inc >= len_of[st_q.head]) begin
                    st_d.full[st_q.head] = 1'b0;
                    st_d.ptr             = '0;
                    st_d.head            = ~st_q.head;
                end else begin
                    st_d.ptr = ptr_inc;
                end
            end else begin
                st_d.rdata = '0;
            end
        end

        if (commit_valid) begin
            st_d.full[commit_slot] = 1'b1;
            st_d.len[commit_slot]  = commit_len;
            st_d.irq               = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_rslot = st_q.head;
    assign ram_raddr = st_q.ptr[AW-1:0];
    assign slot_full = st_q.full;
    assign rd_data   = {{(RW-DW){1'b0}}, st_q.rdata};
    assign irq       = st_q.irq;
    assign ready_cnt = 2'(st_q.full[0]) + 2'(st_q.full[1]);
    assign head_len  = st_q.full[st_q.head] ? len_of[st_q.head] : '0;

    // R1
    commit_to_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> !st_q.full[commit_slot]);

    // R4
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(commit_valid));

    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ready_cnt == 2'd0) |=> (rd_data == '0));

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RW-1:DW] == '0);
endmodule

// File: rtl/usb_out_pingpong.sv
module usb_out_pingpong #(
    parameter int unsigned DEPTH = usb_out_pkg::SLOT_BYTES,
    parameter int unsigned DW    = usb_out_pkg::DATA_W,
    parameter int unsigned RW    = usb_out_pkg::REG_W,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_req,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_eop,
    input  logic          rx_bad,
    output logic          tok_resp_valid,
    output logic          tok_resp_nak,
    output logic          pkt_ack,
    input  logic          rd_en,
    input  logic          irq_clr,
    output logic [RW-1:0] rd_data,
    output logic          irq,
    output logic [1:0]    ready_cnt,
    output logic [LW-1:0] head_len
);
    logic          wr_en, wr_slot, rslot;
    logic [AW-1:0] wr_addr, raddr;
    logic [DW-1:0] wr_data, ram_rdata;
    logic          cm_valid, cm_slot;
    logic [LW-1:0] cm_len;
    logic [1:0]    slot_full;

    ep_rx_fill #(.DEPTH(DEPTH), .DW(DW)) u_fill (
        .clk(clk), .rst_n(rst_n), .tok_req(tok_req),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop), .rx_bad(rx_bad),
        .slot_full(slot_full),
        .tok_resp_valid(tok_resp_valid), .tok_resp_nak(tok_resp_nak), .pkt_ack(pkt_ack),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit_valid(cm_valid), .commit_slot(cm_slot), .commit_len(cm_len)
    );

    pkt_slot_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
        .clk(clk), .we(wr_en), .wslot(wr_slot), .waddr(wr_addr), .wdata(wr_data),
        .rslot(rslot), .raddr(raddr), .rdata(ram_rdata)
    );

    ep_rd_drain #(.DEPTH(DEPTH), .DW(DW), .RW(RW)) u_drain (
        .clk(clk), .rst_n(rst_n),
        .commit_valid(cm_valid), .commit_slot(cm_slot), .commit_len(cm_len),
        .rd_en(rd_en), .irq_clr(irq_clr), .ram_rdata(ram_rdata),
        .ram_rslot(rslot), .ram_raddr(raddr), .slot_full(slot_full),
        .rd_data(rd_data), .irq(irq), .ready_cnt(ready_cnt), .head_len(head_len)
    );

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq) && !$past(irq_clr)) |-> irq);
endmodule

// File: tb/usb_out_pingpong_tb.sv
module usb_out_pingpong_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tok_req, rx_valid, rx_eop, rx_bad, rd_en, irq_clr;
    logic [7:0]  rx_data;
    logic        tok_resp_valid, tok_resp_nak, pkt_ack, irq;
    logic [31:0] rd_data;
    logic [1:0]  ready_cnt;
    logic [6:0]  head_len;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    usb_out_pingpong u_dut (
        .clk(clk), .rst_n(rst_n), .tok_req(tok_req), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_eop(rx_eop), .rx_bad(rx_bad),
        .tok_resp_valid(tok_resp_valid), .tok_resp_nak(tok_resp_nak), .pkt_ack(pkt_ack),
        .rd_en(rd_en), .irq_clr(irq_clr), .rd_data(rd_data), .irq(irq),
        .ready_cnt(ready_cnt), .head_len(head_len)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic token(output logic nak, output logic vld);
        @(negedge clk); tok_req = 1'b1;
        @(negedge clk); tok_req = 1'b0;
        vld = tok_resp_valid; nak = tok_resp_nak;
    endtask

    // sends n bytes base+i, then eop; returns pkt_ack, then waits one more cycle
    task automatic send_pkt(int n, logic [7:0] base, logic bad, output logic ack);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_data = base + 8'(i);
        end
        @(negedge clk); rx_valid = 1'b0; rx_eop = 1'b1; rx_bad = bad;
        @(negedge clk); rx_eop = 1'b0; rx_bad = 1'b0;
        ack = pkt_ack;
        @(negedge clk);
    endtask

    task automatic read_byte(output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic read_pkt(string req, int n, logic [7:0] base);
        logic [31:0] d;
        int bad = 0;
        logic [31:0] first_act = 0, first_exp = 0;
        for (int i = 0; i < n; i++) begin
            read_byte(d);
            if (d !== {24'd0, base + 8'(i)} && bad == 0) begin
                bad = 1; first_act = d; first_exp = {24'd0, base + 8'(i)};
            end
        end
        check(req, "packet bytes", first_act, first_exp);
    endtask

    task automatic t_reset();
        logic n, v;
        check("R10", "rd_data", rd_data, 0);
        check("R10", "irq", 32'(irq), 0);
        check("R10", "ready_cnt", 32'(ready_cnt), 0);
        check("R10", "head_len", 32'(head_len), 0);
    endtask

    task automatic t_empty_read();
        logic [31:0] d;
        read_byte(d);
        check("R9", "empty read data", d, 0);
        check("R9", "ready after empty read", 32'(ready_cnt), 0);
    endtask

    task automatic t_single();
        logic n, v, a;
        token(n, v);
        check("R2", "resp valid", 32'(v), 1);
        check("R2", "ack first token", 32'(n), 0);
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h10;
        check("R4", "no irq on byte", 32'(irq), 0);
        @(negedge clk); rx_valid = 1'b0;
        check("R4", "no irq after byte", 32'(irq), 0);
        send_pkt(4, 8'h11, 1'b0, a);
        check("R4", "pkt_ack", 32'(a), 1);
        check("R4", "irq set", 32'(irq), 1);
        check("R7", "ready 1", 32'(ready_cnt), 1);
        check("R7", "head_len 5", 32'(head_len), 5);
        read_pkt("R6", 5, 8'h10);
        check("R7", "ready 0", 32'(ready_cnt), 0);
        check("R7", "head_len 0", 32'(head_len), 0);
        check("R8", "irq held", 32'(irq), 1);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        check("R8", "irq cleared", 32'(irq), 0);
    endtask

    task automatic t_pingpong();
        logic n, v, a;
        logic [31:0] d;
        token(n, v); send_pkt(3, 8'hA0, 1'b0, a);
        token(n, v);
        check("R2", "second slot ack", 32'(n), 0);
        send_pkt(6, 8'hB0, 1'b0, a);
        check("R7", "ready 2", 32'(ready_cnt), 2);
        check("R7", "head_len oldest", 32'(head_len), 3);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        check("R8", "irq stays with two waiting", 32'(irq), 1);
        token(n, v);
        check("R3", "nak both full", 32'(n), 1);
        read_byte(d);
        check("R1", "oldest first", d, 32'hA0);
        token(n, v);
        check("R3", "nak partly read", 32'(n), 1);
        read_byte(d); read_byte(d);
        check("R1", "last of first", d, 32'hA2);
        check("R7", "head_len next", 32'(head_len), 6);
        token(n, v);
        check("R3", "ack after slot drained", 32'(n), 0);
        send_pkt(2, 8'hC0, 1'b0, a);
        read_pkt("R1", 6, 8'hB0);
        read_pkt("R1", 2, 8'hC0);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        check("R8", "irq clear single", 32'(irq), 0);
    endtask

    task automatic t_discard();
        logic n, v, a;
        token(n, v); send_pkt(5, 8'h50, 1'b1, a);
        check("R5", "bad no ack", 32'(a), 0);
        check("R5", "bad no irq", 32'(irq), 0);
        check("R5", "bad ready", 32'(ready_cnt), 0);
        token(n, v);
        check("R5", "ack after bad", 32'(n), 0);
        send_pkt(65, 8'h00, 1'b0, a);
        check("R5", "oversize no ack", 32'(a), 0);
        check("R5", "oversize no irq", 32'(irq), 0);
        check("R5", "oversize ready", 32'(ready_cnt), 0);
        token(n, v);
        check("R5", "ack after oversize", 32'(n), 0);
        send_pkt(64, 8'h40, 1'b0, a);
        check("R1", "full size ack", 32'(a), 1);
        check("R7", "head_len 64", 32'(head_len), 64);
        read_pkt("R1", 64, 8'h40);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic t_stray();
        logic n, v, a;
        logic [31:0] d;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_data = 8'hEE;
        end
        @(negedge clk); rx_valid = 1'b0; rx_eop = 1'b1;
        @(negedge clk); rx_eop = 1'b0;
        check("R11", "no ack for stray", 32'(pkt_ack), 0);
        @(negedge clk);
        check("R11", "ready after stray", 32'(ready_cnt), 0);
        read_byte(d);
        check("R9", "empty read again", d, 0);
        token(n, v); send_pkt(2, 8'h70, 1'b0, a);
        check("R11", "head_len unaffected", 32'(head_len), 2);
        read_pkt("R9", 2, 8'h70);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tok_req = 0; rx_valid = 0; rx_eop = 0; rx_bad = 0;
        rx_data = 0; rd_en = 0; irq_clr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty_read();
        t_single();
        t_pingpong();
        t_discard();
        t_stray();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule